// File: doc/BRIEF.md
# Tick-Driven Watchdog with Expiry Steering

This block is a watchdog timer controlled through one byte-wide control register. The two lowest bits of that register pick a resolution. The next five bits pick a multiplier. Together they set a timeout that is counted in ticks of an external 16 Hz strobe, so one tick is a sixteenth of a second. Software keeps the watchdog from expiring by writing the control register or by reading it. Either access restarts the countdown.

When the countdown runs out, a sticky flag is set. The top bit of the control register decides what happens next. If it is set, the block asks for a system reset and disarms itself. If it is clear, the block raises a single interrupt pulse. A small byte register file (control, flags and a calendar byte whose century bit takes part in the reset path) is reached through a two-bit register select with separate read and write strobes.

Top module: `wdog_steer`

## Requirements
- R1: The control register holds the steering bit in bit 7, the multiplier M in bits 6:2 and the resolution code S in bits 1:0. After a kick, expiry happens on the M×4^S-th tick that follows, so the timeout is 1, 4, 16 or 64 times M.
- R2: Writing 0x00 to the control register disarms the watchdog. A nonzero value whose multiplier field is 0 also leaves it disarmed. No expiry follows in either case.
- R3: Every write to the control register stores the byte, clears the expiry flag and restarts the countdown from the new value.
- R4: A read of the control register returns the stored byte, clears the expiry flag and restarts the countdown from the stored value.
- R5: On expiry the expiry flag is set. It appears as bit 7 of the `flags` output and of the flags register (select 1); the other flag bits read 0.
- R6: On expiry with bit 7 set, three things happen at the same clock edge: the control register becomes 0x00, bit 6 of the calendar byte is cleared, and `sys_rst_req` pulses high for exactly one cycle. The watchdog then stays disarmed.
- R7: On expiry with bit 7 clear, `wd_irq` pulses high for exactly one cycle and the control register keeps its value. The countdown then stops until the next kick.
- R8: Register select 0 is control, select 1 is flags (writes to it have no effect), select 2 is the calendar byte (read/write), and select 3 reads 0x00.
- R9: While `rst_n` is low, the control register, calendar byte, countdown and flag are cleared and both pulse outputs are low.
- R10: A kick in the same cycle as a tick consumes that tick, so the full timeout counts from the following ticks. When a read and a write arrive together, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of select 0 kicks) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register, combinational |
| flags | output | 8 | Flags byte, bit 7 is the expiry flag |
| sys_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its fixed byte layout: a 5-bit multiplier, a 2-bit resolution code and the 11-bit countdown derived from them. This makes every timeout from 1 to 1984 ticks reachable, including the longest one, within the run. Random control bytes cover all four resolution codes and both steering choices. Directed cases cover timeouts of one tick, a kick that coincides with a tick, a disarming zero write and reset in the middle of a count.

// File: rtl/wdog_steer.sv
module wdog_steer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] flags,
  output logic       sys_rst_req,
  output logic       wd_irq
);
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [7:0]       ctrl_q, cal_q;
  logic             flag_q, armed_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] span(input logic [7:0] v);
    span = CNT_W'(v[RES_W +: MULT_W]) << (2 * v[RES_W-1:0]);
  endfunction

  wire              sel_ctrl  = (reg_addr == 2'd0);
  wire              wr_ctrl   = reg_wr && sel_ctrl;
  wire              kick      = wr_ctrl || (reg_rd && sel_ctrl);
  wire [CNT_W-1:0]  load_span = span(wr_ctrl ? wr_data : ctrl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      cal_q       <= '0;
      flag_q      <= 1'b0;
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      sys_rst_req <= 1'b0;
      wd_irq      <= 1'b0;
    end else begin
      sys_rst_req <= 1'b0;
      wd_irq      <= 1'b0;
      if (reg_wr && reg_addr == 2'd2) cal_q <= wr_data;
      if (kick) begin
        if (wr_ctrl) ctrl_q <= wr_data;
        flag_q  <= 1'b0;
        cnt_q   <= load_span;
        armed_q <= (load_span != '0);
      end else if (armed_q && tick16) begin
        if (cnt_q == CNT_W'(1)) begin
          flag_q  <= 1'b1;
          armed_q <= 1'b0;
          if (ctrl_q[7]) begin
            ctrl_q      <= '0;
            cal_q[6]    <= 1'b0;
            sys_rst_req <= 1'b1;
          end else begin
            wd_irq <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    rd_data = ctrl_q;
      2'd1:    rd_data = {flag_q, 7'b0};
      2'd2:    rd_data = cal_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign flags = {flag_q, 7'b0};

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  p_rst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (ctrl_q == 8'h00 && !cal_q[6] && !armed_q));
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |=> !wd_irq);
  p_irq_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> !armed_q);
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req && wd_irq));
  p_zero_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_data == 8'h00) |=> !armed_q);
  p_kick_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !flag_q);
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (sys_rst_req || wd_irq));
endmodule

// File: tb/wdog_steer_test.sv
module wdog_steer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, flags;
  logic       sys_rst_req, wd_irq;

  int checks = 0, errors = 0;
  int rst_cnt = 0, irq_cnt = 0;

  wdog_steer uut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (sys_rst_req) rst_cnt++;
    if (wd_irq) irq_cnt++;
  end

  function automatic int tmo(input logic [7:0] v);
    return int'(v[6:2]) * (1 << (2 * v[1:0]));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = rd_data;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick16 = 1'b1;
      @(negedge clk); tick16 = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    int r0, i0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 flags", flags, 0);
    chk("R9 pulses", {sys_rst_req, wd_irq}, 0);
    rd(2'd0, d); chk("R9 ctrl", d, 0);
    rd(2'd2, d); chk("R9 calendar", d, 0);

    // R8 register map
    wr(2'd2, 8'h5A); rd(2'd2, d); chk("R8 calendar rw", d, 8'h5A);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R8 flags write ignored", d, 0);
    rd(2'd3, d); chk("R8 select3", d, 0);

    // R1 / R7 / R5 interrupt path, T = 4
    wr(2'd0, 8'h05);
    ticks(3); chk("R1 early", irq_cnt + rst_cnt, 0);
    ticks(1); chk("R7 irq single", irq_cnt, 1); chk("R5 flag", flags, 8'h80);
    rd(2'd1, d); chk("R5 flags reg", d, 8'h80);
    ticks(10); chk("R7 stopped", irq_cnt, 1);
    rd(2'd0, d); chk("R4 read value kept", d, 8'h05);
    chk("R4 read clears flag", flags, 0);
    ticks(3); chk("R4 restart early", irq_cnt, 1);
    ticks(1); chk("R4 restart expiry", irq_cnt, 2);

    // R3 rewrite restarts
    wr(2'd0, 8'h05); ticks(2);
    wr(2'd0, 8'h05); ticks(3); chk("R3 restart early", irq_cnt, 2);
    ticks(1); chk("R3 expiry", irq_cnt, 3);
    wr(2'd0, 8'h04); chk("R3 write clears flag", flags, 0);
    ticks(1); chk("R1 one tick", irq_cnt, 4);

    // R6 reset steering, T = 2
    wr(2'd2, 8'h7F);
    wr(2'd0, 8'h88);
    ticks(1); chk("R6 early", rst_cnt, 0);
    ticks(1); chk("R6 rst single", rst_cnt, 1); chk("R6 no irq", irq_cnt, 4);
    chk("R6 flag", flags, 8'h80);
    rd(2'd2, d); chk("R6 calendar bit6", d, 8'h3F);
    rd(2'd0, d); chk("R6 ctrl zero", d, 0);
    ticks(20); chk("R6 stays disarmed", rst_cnt + irq_cnt, 5);

    // R2 disarm
    wr(2'd0, 8'h05); ticks(2); wr(2'd0, 8'h00);
    ticks(30); chk("R2 zero write", irq_cnt, 4);
    wr(2'd0, 8'h03); ticks(30); chk("R2 zero multiplier", irq_cnt + rst_cnt, 5);

    // R10 kick with simultaneous tick
    @(negedge clk); reg_addr = 2'd0; wr_data = 8'h05; reg_wr = 1'b1; tick16 = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tick16 = 1'b0;
    ticks(3); chk("R10 tick consumed", irq_cnt, 4);
    ticks(1); chk("R10 expiry", irq_cnt, 5);
    @(negedge clk); reg_addr = 2'd0; wr_data = 8'h09; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
    rd(2'd0, d); chk("R10 write wins", d, 8'h09);
    wr(2'd0, 8'h00);

    // R9 mid-count reset
    wr(2'd2, 8'h44); wr(2'd0, 8'h85); ticks(2);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, d); chk("R9 ctrl cleared", d, 0);
    rd(2'd2, d); chk("R9 calendar cleared", d, 0);
    ticks(10); chk("R9 no expiry", rst_cnt + irq_cnt, 6);

    // R1 random timeouts with both steerings
    for (int k = 0; k < 10; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (v[6:2] == 5'd0) v[2] = 1'b1;
      r0 = rst_cnt; i0 = irq_cnt;
      wr(2'd0, v);
      if (tmo(v) > 1) ticks(tmo(v) - 1);
      chk("R1 random early", (rst_cnt - r0) + (irq_cnt - i0), 0);
      chk("R5 random flag low", flags, 0);
      ticks(1);
      chk("R6 random rst", rst_cnt - r0, v[7] ? 1 : 0);
      chk("R7 random irq", irq_cnt - i0, v[7] ? 0 : 1);
      chk("R5 random flag", flags, 8'h80);
      rd(2'd0, d); chk("R6 R7 random ctrl", d, v[7] ? 0 : v);
      wr(2'd0, 8'h00);
    end

    summary();
  end
endmodule